// File: doc/BRIEF.md
# Wait-for-Event Sleep Controller

This block makes the sleep decision for a processor core's wait-for-event instruction. It holds a single sticky event flag. Three sources can set the flag: a send-event pulse from the core, an event line from outside the core, and an interrupt line that becomes pending while the pend-to-event enable is on. That last case applies even when the interrupt is masked by a global priority mask. Handling an exception does not clear the flag. Only a wait-for-event instruction clears it.

When the core presents a wait-for-event strobe, the block checks the flag. If the flag is set, the block consumes it and pulses the retire output, so execution carries on without sleeping. If the flag is clear, the block raises the sleep output and holds it until a wake event arrives. When that happens it drops sleep and pulses retire. An event that was latched before a wait makes that first wait return at once. Software is therefore expected to wrap the wait in a loop that re-tests its own condition.

All pins are single-cycle control and status levels or pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure. Every output is registered.

Top module: `evt_sleep_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the next outputs are `sleep_o`=0, `retire_o`=0 and `evt_flag_o`=0.
- R2: A `wfe_i` strobe while awake with `evt_flag_o`=1 gives, one cycle later, `retire_o`=1, `sleep_o`=0 and `evt_flag_o`=0, provided no set condition is present in the same cycle.
- R3: A `wfe_i` strobe while awake with `evt_flag_o`=0 gives, one cycle later, `sleep_o`=1 and `retire_o`=0.
- R4: A `sev_i` pulse or an `ext_evt_i` pulse sets `evt_flag_o` to 1 in the next cycle.
- R5: While `pend_evt_en_i`=1, a 0-to-1 change on any bit of `irq_pend_i` sets the flag in the next cycle. While `pend_evt_en_i`=0, such a change does not affect the flag.
- R6: A `irq_pend_i` bit that stays at 1 sets the flag only once, on the cycle it rises.
- R7: The flag stays set until a `wfe_i` strobe consumes it. Neither idle cycles nor pending lines falling clear it.
- R8: If a set condition and a `wfe_i` strobe with the flag set occur in the same cycle, the strobe retires and the flag is 1 afterwards.
- R9: While asleep, any set condition, or a flag that is already set, makes the next cycle show `sleep_o`=0, `retire_o`=1 and `evt_flag_o`=0.
- R10: A `wfe_i` strobe while `sleep_o`=1 has no effect. Sleep stays asserted and no retire pulse is produced.
- R11: After a pending interrupt has set the flag, the first wait retires at once and a second wait with no new event enters sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfe_i | input | 1 | Wait-for-event instruction strobe, one cycle |
| sev_i | input | 1 | Send-event pulse from the core |
| ext_evt_i | input | 1 | External event pulse |
| pend_evt_en_i | input | 1 | Enable: interrupt becoming pending counts as an event |
| irq_pend_i | input | NUM_IRQ | Pending level per interrupt line |
| sleep_o | output | 1 | Core is in the low-power wait state |
| retire_o | output | 1 | One-cycle pulse: the wait completed, continue with next instruction |
| evt_flag_o | output | 1 | Current value of the event flag |

## Verification
The hardest case to reach is a set condition that lands in the same cycle as the strobe. With the flag clear, the block goes to sleep holding a fresh event and must wake in the very next cycle. With the flag set, the strobe must retire and still leave the flag standing. The directed phase builds the set-flag collision explicitly with a simultaneous send-event and strobe. A randomized phase then drives dense, correlated pulses on every source, including held and re-rising pending lines, so both collision shapes recur many times. A behavioural reference model checks every cycle of it.

// File: rtl/evt_sleep_pkg.sv
package evt_sleep_pkg;
  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } slp_state_t;
endpackage

// File: rtl/evt_pend_edge.sv
module evt_pend_edge #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  output logic [NUM_IRQ-1:0] rise_o
);
  logic [NUM_IRQ-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_pend_i;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign rise_o[g] = irq_pend_i[g] & ~prev_q[g];

    // R6: a line held high across two sampled cycles never reports a new rise
    assert_no_repeat_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(irq_pend_i[g]) && irq_pend_i[g]) |-> !rise_o[g]);
  end
endmodule

// File: rtl/evt_flag_reg.sv
module evt_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  input  logic refill_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    if (consume_i) flag_d = refill_i & set_i;
    else           flag_d = flag_q | set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R7: only a consume may take the flag down
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !consume_i) |=> flag_q);
  // R4: any set without a consume is seen next cycle
  assert_set_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !consume_i) |=> flag_q);
endmodule

// File: rtl/evt_sleep_fsm.sv
module evt_sleep_fsm
  import evt_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfe_i,
  input  logic set_i,
  input  logic flag_i,
  output logic consume_o,
  output logic refill_o,
  output logic sleep_o,
  output logic retire_o
);
  slp_state_t state_q, state_d;
  logic       retire_q, retire_d;
  logic       wake;

  assign wake = set_i | flag_i;

  always_comb begin
    state_d   = state_q;
    retire_d  = 1'b0;
    consume_o = 1'b0;
    refill_o  = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (wfe_i) begin
          consume_o = 1'b1;
          refill_o  = 1'b1;
          if (flag_i) retire_d = 1'b1;
          else        state_d  = ST_ASLEEP;
        end
      end
      ST_ASLEEP: begin
        if (wake) begin
          state_d   = ST_AWAKE;
          retire_d  = 1'b1;
          consume_o = 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_AWAKE;
      retire_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      retire_q <= retire_d;
    end
  end

  assign sleep_o  = (state_q == ST_ASLEEP);
  assign retire_o = retire_q;

  assert_hit_retires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wfe_i && flag_i) |=> (retire_o && !sleep_o));
  assert_miss_sleeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wfe_i && !flag_i) |=> (sleep_o && !retire_o));
  assert_wake_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && wake) |=> (!sleep_o && retire_o));
  assert_wfe_ignored_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && !wake) |=> (sleep_o && !retire_o));
endmodule

// File: rtl/evt_sleep_ctrl.sv
module evt_sleep_ctrl #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfe_i,
  input  logic               sev_i,
  input  logic               ext_evt_i,
  input  logic               pend_evt_en_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  output logic               sleep_o,
  output logic               retire_o,
  output logic               evt_flag_o
);
  logic [NUM_IRQ-1:0] rise;
  logic               pend_evt;
  logic               set_evt;
  logic               consume;
  logic               refill;

  evt_pend_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pend_i (irq_pend_i),
    .rise_o     (rise)
  );

  assign pend_evt = pend_evt_en_i & (|rise);
  assign set_evt  = sev_i | ext_evt_i | pend_evt;

  evt_flag_reg u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_evt),
    .consume_i (consume),
    .refill_i  (refill),
    .flag_o    (evt_flag_o)
  );

  evt_sleep_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wfe_i     (wfe_i),
    .set_i     (set_evt),
    .flag_i    (evt_flag_o),
    .consume_o (consume),
    .refill_o  (refill),
    .sleep_o   (sleep_o),
    .retire_o  (retire_o)
  );

  // R1: reset leaves all outputs low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!sleep_o && !retire_o && !evt_flag_o));
  // R8: a collision of set and a retiring wait leaves the flag up
  assert_collision_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wfe_i && evt_flag_o && set_evt) |=> (retire_o && evt_flag_o));
  // R5: with the enable off, a pending rise alone cannot raise the flag
  assert_pend_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_flag_o && !sleep_o && !pend_evt_en_i && !sev_i && !ext_evt_i) |=> !evt_flag_o);
endmodule

// File: tb/evt_sleep_ctrl_test.sv
module evt_sleep_ctrl_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wfe = 1'b0, sev = 1'b0, ext = 1'b0, en = 1'b0;
  logic [N-1:0] irq = '0;
  logic         sleep_w, retire_w, flag_w;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit started = 1'b0;

  evt_sleep_ctrl #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .wfe_i(wfe), .sev_i(sev), .ext_evt_i(ext),
    .pend_evt_en_i(en), .irq_pend_i(irq),
    .sleep_o(sleep_w), .retire_o(retire_w), .evt_flag_o(flag_w)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_flag = 0, m_sleep = 0, m_retire = 0;
  int m_prev[N];
  initial for (int i = 0; i < N; i++) m_prev[i] = 0;

  always @(posedge clk) begin
    int rise;
    int setc;
    rise = 0;
    for (int i = 0; i < N; i++) if (irq[i] && m_prev[i] == 0) rise = 1;
    setc = (sev || ext || (en && rise)) ? 1 : 0;
    if (!rst_n) begin
      m_flag = 0; m_sleep = 0; m_retire = 0;
      for (int i = 0; i < N; i++) m_prev[i] = 0;
    end else begin
      if (m_sleep == 0) begin
        if (wfe) begin
          if (m_flag != 0) m_retire = 1;
          else begin m_sleep = 1; m_retire = 0; end
          m_flag = setc;
        end else begin
          m_retire = 0;
          if (setc != 0) m_flag = 1;
        end
      end else begin
        if (setc != 0 || m_flag != 0) begin
          m_sleep = 0; m_retire = 1; m_flag = 0;
        end else m_retire = 0;
      end
      for (int i = 0; i < N; i++) m_prev[i] = irq[i] ? 1 : 0;
    end
    started = 1'b1;
    cyc++;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (sleep_w !== m_sleep[0] || retire_w !== m_retire[0] || flag_w !== m_flag[0]) begin
        mismatched++;
        $display("FAIL model R1..R11 cycle %0d: sleep/retire/flag actual %b%b%b expected %0d%0d%0d",
                 cyc, sleep_w, retire_w, flag_w, m_sleep, m_retire, m_flag);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    chk("R1 sleep", sleep_w, 1'b0);
    chk("R1 retire", retire_w, 1'b0);
    chk("R1 flag", flag_w, 1'b0);
    rst_n = 1'b1;
    tick();

    sev = 1'b1; tick(); sev = 1'b0;
    chk("R4 sev sets flag", flag_w, 1'b1);
    repeat (5) tick();
    chk("R7 flag sticky", flag_w, 1'b1);

    wfe = 1'b1; tick(); wfe = 1'b0;
    chk("R2 retire", retire_w, 1'b1);
    chk("R2 flag cleared", flag_w, 1'b0);
    chk("R2 no sleep", sleep_w, 1'b0);
    tick();
    chk("R2 retire is a pulse", retire_w, 1'b0);

    wfe = 1'b1; tick(); wfe = 1'b0;
    chk("R3 sleep", sleep_w, 1'b1);
    chk("R3 no retire", retire_w, 1'b0);
    wfe = 1'b1; tick(); wfe = 1'b0;
    chk("R10 still asleep", sleep_w, 1'b1);
    chk("R10 no retire", retire_w, 1'b0);

    ext = 1'b1; tick(); ext = 1'b0;
    chk("R9 wake sleep", sleep_w, 1'b0);
    chk("R9 wake retire", retire_w, 1'b1);
    chk("R9 flag consumed", flag_w, 1'b0);
    tick();

    ext = 1'b1; tick(); ext = 1'b0;
    chk("R4 ext sets flag", flag_w, 1'b1);
    wfe = 1'b1; tick(); wfe = 1'b0;
    tick();

    en = 1'b0; irq[2] = 1'b1; tick();
    chk("R5 disabled pend ignored", flag_w, 1'b0);
    irq[2] = 1'b0; tick();
    en = 1'b1; irq[2] = 1'b1; tick();
    chk("R5 enabled pend sets", flag_w, 1'b1);
    irq[2] = 1'b0; tick();
    chk("R7 pend fall keeps flag", flag_w, 1'b1);
    irq[2] = 1'b1; tick();
    wfe = 1'b1; tick(); wfe = 1'b0;
    chk("R6 consumed", flag_w, 1'b0);
    repeat (4) tick();
    chk("R6 held line no re-set", flag_w, 1'b0);
    irq = '0; tick();

    irq[3] = 1'b1; tick(); irq[3] = 1'b0;
    wfe = 1'b1; tick(); wfe = 1'b0;
    chk("R11 first wait retires", retire_w, 1'b1);
    chk("R11 first wait awake", sleep_w, 1'b0);
    tick();
    wfe = 1'b1; tick(); wfe = 1'b0;
    chk("R11 second wait sleeps", sleep_w, 1'b1);
    sev = 1'b1; tick(); sev = 1'b0;
    tick();

    sev = 1'b1; tick();
    wfe = 1'b1; tick(); wfe = 1'b0; sev = 1'b0;
    chk("R8 collision retire", retire_w, 1'b1);
    chk("R8 collision keeps flag", flag_w, 1'b1);
    tick();

    for (int k = 0; k < 4000; k++) begin
      wfe = ($urandom_range(0, 3) == 0);
      sev = ($urandom_range(0, 9) == 0);
      ext = ($urandom_range(0, 11) == 0);
      en  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 4) == 0) irq = N'($urandom);
      rst_n = ($urandom_range(0, 499) != 0);
      tick();
    end
    rst_n = 1'b1; wfe = 1'b0; sev = 1'b0; ext = 1'b0;
    tick(); tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule